// File: doc/BRIEF.md
# Exception Status Save Register Bank

This block keeps the saved status word and return address of a processor at the moments when control is diverted. There are four save banks, one per class of event: maskable interrupt or software exception, non-maskable interrupt, debug or trap entry, and table-call instruction. When an event request is raised, the current status word and program counter are captured into the bank of that class. Some bits of each bank are forced to zero. If several classes are requested in the same cycle, a fixed priority decides which single bank is written.

Software reads and writes each saved register through a 3-bit register-select port. A read of the debug bank returns zero unless the debug read window is open. The window opens when a vector fetch to the debug-trap handler address is seen, and it closes on the debug return strobe. A return strobe sends the stored status word and PC of its bank out on the restore port for exactly one cycle.

The restore port is a stream that carries `ret_valid` only and has no ready. The consumer must take the beat in the cycle it is valid, and the bank never stalls. All other pins are plain control and status signals.

Top module: `xstat_save_bank`

## Requirements
- R1: After reset every saved register reads as zero, `ret_valid` is low and the debug read window is closed.
- R2: A request on `evt_req[0]` (maskable interrupt or software exception) captures the inputs into bank 0. The status word keeps only bits 11 and 7..0 (mask 0x0000_08FF). The PC keeps bits 25..1 (mask 0x03FF_FFFE).
- R3: A request on `evt_req[1]` (non-maskable) captures into bank 1, and a request on `evt_req[3]` (table-call) captures into bank 3. In both banks the status word keeps bits 11..0 (mask 0x0000_0FFF) and the PC keeps bits 31..1 (mask 0xFFFF_FFFE).
- R4: A request on `evt_req[2]` (trap, debug trap, debug break or single step) captures into bank 2 with the bank-1 masks. Reads of bank 2 return zero unless the window is open. A cycle with `vec_valid` high and `vec_addr` equal to 0x0000_0060 opens the window. Any other vector address leaves the window unchanged.
- R5: When several event requests arrive in one cycle, only one bank is written. The priority is bank 1 (non-maskable), then bank 2 (debug), then bank 0 (maskable), then bank 3 (table-call).
- R6: A write with `reg_we` high updates the register chosen by `reg_sel` at the next clock edge. `reg_sel[2:1]` picks the bank and `reg_sel[0]` picks the field (0 = status word, 1 = PC). The write applies the same masks as capture, so PC bit 0 is always stored as 0.
- R7: When an event capture and a software write target the same bank in one cycle, the capture wins and the write is dropped. A write to a different bank in that cycle still takes effect.
- R8: A return strobe `ret_req[b]` makes `ret_valid` high for one cycle, starting at the next edge. In that cycle `ret_bank` is b and `ret_psw` and `ret_pc` hold the values bank b had when the strobe was sampled. The restore path is not gated by the window. Simultaneous strobes follow the R5 priority.
- R9: A debug return strobe (`ret_req[2]`) closes the debug read window at the next edge.
- R10: A second event of the same class overwrites the earlier saved values of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req | input | 4 | Save requests, one bit per bank (0 maskable/software, 1 non-maskable, 2 debug/trap, 3 table-call) |
| cur_psw | input | 32 | Current status word to capture |
| cur_pc | input | 32 | Current return PC to capture |
| vec_valid | input | 1 | A handler vector fetch happens this cycle |
| vec_addr | input | 32 | Address of that vector fetch |
| reg_sel | input | 3 | Register select: bank in [2:1], field in [0] |
| reg_we | input | 1 | Software write strobe |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| ret_req | input | 4 | Return strobes, one bit per bank |
| ret_valid | output | 1 | Restore beat valid (no ready) |
| ret_bank | output | 2 | Bank being restored |
| ret_psw | output | 32 | Restored status word |
| ret_pc | output | 32 | Restored PC |

## Verification
The hardest case to reach is a collision: an event capture and a software write aimed at the same bank in the same edge, with further requests of lower priority pending at that moment. The scoreboard driver raises several `evt_req` bits together with `reg_we` in one cycle, and it separately aims the write at a bank that loses arbitration, so that both the dropped write and the surviving write show up in later reads. The gated debug read is tested across a full window cycle: closed, then a decoy vector address, then the real vector, then a debug return. A restore of bank 2 is also done while the window is closed, to show that the restore path ignores the gate.

// File: rtl/xsave_pkg.sv
package xsave_pkg;
  localparam int XLEN   = 32;
  localparam int NBANK  = 4;
  localparam int BIDX_W = $clog2(NBANK);
  localparam int SEL_W  = BIDX_W + 1;

  typedef enum logic [BIDX_W-1:0] {
    BK_INT  = 2'd0,
    BK_NMI  = 2'd1,
    BK_DBG  = 2'd2,
    BK_CALL = 2'd3
  } bank_e;

  localparam logic [XLEN-1:0] PSW_MASK_INT = 32'h0000_08FF;
  localparam logic [XLEN-1:0] PSW_MASK_STD = 32'h0000_0FFF;
  localparam logic [XLEN-1:0] PC_MASK_INT  = 32'h03FF_FFFE;
  localparam logic [XLEN-1:0] PC_MASK_STD  = 32'hFFFF_FFFE;

  // rank 0 is the strongest request
  function automatic logic [BIDX_W-1:0] prio_at(input int rank);
    case (rank)
      0:       prio_at = BK_NMI;
      1:       prio_at = BK_DBG;
      2:       prio_at = BK_INT;
      default: prio_at = BK_CALL;
    endcase
  endfunction
endpackage

// File: rtl/xsave_arb.sv
module xsave_arb import xsave_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] req,
  output logic [NBANK-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int p = NBANK - 1; p >= 0; p--) begin
      if (req[prio_at(p)]) begin
        grant = '0;
        grant[prio_at(p)] = 1'b1;
      end
    end
  end

  // R5
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  // R5
  grant_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> ($countones(grant) == 1));
  // R5
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[BK_NMI] |-> grant[BK_NMI]);
endmodule

// File: rtl/xsave_bank.sv
module xsave_bank import xsave_pkg::*; #(
  parameter logic [XLEN-1:0] PSW_MASK = PSW_MASK_STD,
  parameter logic [XLEN-1:0] PC_MASK  = PC_MASK_STD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [XLEN-1:0] cap_psw,
  input  logic [XLEN-1:0] cap_pc,
  input  logic            wr_psw,
  input  logic            wr_pc,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] psw_q,
  output logic [XLEN-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw_q <= '0;
      pc_q  <= '0;
    end else if (cap_en) begin
      psw_q <= cap_psw & PSW_MASK;
      pc_q  <= cap_pc & PC_MASK;
    end else begin
      if (wr_psw) psw_q <= wdata & PSW_MASK;
      if (wr_pc)  pc_q  <= wdata & PC_MASK;
    end
  end

  // R6
  psw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_psw) |=> $stable(psw_q));
  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_pc) |=> $stable(pc_q));
  // R7
  cap_over_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && wr_pc) |=> (pc_q == ($past(cap_pc) & PC_MASK)));
endmodule

// File: rtl/xsave_dbgwin.sv
module xsave_dbgwin import xsave_pkg::*; #(
  parameter logic [XLEN-1:0] DBG_VECTOR = 32'h0000_0060
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vec_valid,
  input  logic [XLEN-1:0] vec_addr,
  input  logic            close,
  output logic            open_q
);
  logic hit;
  assign hit = vec_valid && (vec_addr == DBG_VECTOR);

  always_ff @(posedge clk) begin
    if (!rst_n)      open_q <= 1'b0;
    else if (close)  open_q <= 1'b0;
    else if (hit)    open_q <= 1'b1;
  end

  // R9
  close_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !open_q);
  // R4
  decoy_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !(vec_valid && vec_addr == DBG_VECTOR)) |=> !open_q);
endmodule

// File: rtl/xsave_ret.sv
module xsave_ret import xsave_pkg::*; (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NBANK-1:0]           grant,
  input  logic [NBANK-1:0][XLEN-1:0] psw_arr,
  input  logic [NBANK-1:0][XLEN-1:0] pc_arr,
  output logic                       valid,
  output logic [BIDX_W-1:0]          bank,
  output logic [XLEN-1:0]            psw,
  output logic [XLEN-1:0]            pc
);
  logic [XLEN-1:0]   sel_psw, sel_pc;
  logic [BIDX_W-1:0] sel_idx;

  always_comb begin
    sel_psw = '0;
    sel_pc  = '0;
    sel_idx = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (grant[i]) begin
        sel_psw = sel_psw | psw_arr[i];
        sel_pc  = sel_pc | pc_arr[i];
        sel_idx = sel_idx | BIDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      bank  <= '0;
      psw   <= '0;
      pc    <= '0;
    end else begin
      valid <= |grant;
      if (|grant) begin
        bank <= sel_idx;
        psw  <= sel_psw;
        pc   <= sel_pc;
      end
    end
  end

  // R8
  ret_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> !valid);
  // R8
  ret_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> valid);
endmodule

// File: rtl/xstat_save_bank.sv
module xstat_save_bank import xsave_pkg::*; #(
  parameter logic [XLEN-1:0] DBG_VECTOR = 32'h0000_0060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBANK-1:0]  evt_req,
  input  logic [XLEN-1:0]   cur_psw,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              vec_valid,
  input  logic [XLEN-1:0]   vec_addr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_we,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  input  logic [NBANK-1:0]  ret_req,
  output logic              ret_valid,
  output logic [BIDX_W-1:0] ret_bank,
  output logic [XLEN-1:0]   ret_psw,
  output logic [XLEN-1:0]   ret_pc
);
  logic [NBANK-1:0]            cap_grant, ret_grant;
  logic [NBANK-1:0][XLEN-1:0]  bank_psw, bank_pc;
  logic [BIDX_W-1:0]           rd_bank;
  logic                        win_open;

  assign rd_bank = reg_sel[SEL_W-1:1];

  xsave_arb u_cap_arb (
    .clk(clk), .rst_n(rst_n), .req(evt_req), .grant(cap_grant)
  );

  xsave_arb u_ret_arb (
    .clk(clk), .rst_n(rst_n), .req(ret_req), .grant(ret_grant)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic [XLEN-1:0] PSW_M = (i == int'(BK_INT)) ? PSW_MASK_INT : PSW_MASK_STD;
    localparam logic [XLEN-1:0] PC_M  = (i == int'(BK_INT)) ? PC_MASK_INT  : PC_MASK_STD;
    logic hit_w;
    assign hit_w = reg_we && (rd_bank == BIDX_W'(i));

    xsave_bank #(.PSW_MASK(PSW_M), .PC_MASK(PC_M)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cap_en(cap_grant[i]), .cap_psw(cur_psw), .cap_pc(cur_pc),
      .wr_psw(hit_w && !reg_sel[0]), .wr_pc(hit_w && reg_sel[0]),
      .wdata(reg_wdata),
      .psw_q(bank_psw[i]), .pc_q(bank_pc[i])
    );
  end

  xsave_dbgwin #(.DBG_VECTOR(DBG_VECTOR)) u_win (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .close(ret_grant[BK_DBG]), .open_q(win_open)
  );

  always_comb begin
    if (rd_bank == BK_DBG && !win_open) reg_rdata = '0;
    else if (reg_sel[0])                reg_rdata = bank_pc[rd_bank];
    else                                reg_rdata = bank_psw[rd_bank];
  end

  xsave_ret u_ret (
    .clk(clk), .rst_n(rst_n), .grant(ret_grant),
    .psw_arr(bank_psw), .pc_arr(bank_pc),
    .valid(ret_valid), .bank(ret_bank), .psw(ret_psw), .pc(ret_pc)
  );

  // R5
  nmi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_req[BK_NMI] |=> (bank_psw[BK_NMI] == ($past(cur_psw) & PSW_MASK_STD)));
  // R2
  int_pc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_grant[BK_INT]) |=> (bank_pc[BK_INT][XLEN-1:26] == '0));
endmodule

// File: tb/xstat_save_bank_tb.sv
module xstat_save_bank_tb;
  import xsave_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  evt_req = '0, ret_req = '0;
  logic [31:0] cur_psw = '0, cur_pc = '0, vec_addr = '0, reg_wdata = '0;
  logic        vec_valid = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_rdata, ret_psw, ret_pc;
  logic        ret_valid;
  logic [1:0]  ret_bank;

  xstat_save_bank u_dut (
    .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .cur_psw(cur_psw), .cur_pc(cur_pc),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ret_req(ret_req),
    .ret_valid(ret_valid), .ret_bank(ret_bank), .ret_psw(ret_psw), .ret_pc(ret_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_psw [4];
  logic [31:0] m_pc  [4];
  bit m_win = 0;

  typedef struct packed { logic [1:0] b; logic [31:0] psw; logic [31:0] pc; } ret_t;
  ret_t exp_q[$];

  function automatic int pick(logic [3:0] r);
    if (r[1]) return 1;
    if (r[2]) return 2;
    if (r[0]) return 0;
    if (r[3]) return 3;
    return -1;
  endfunction
  function automatic logic [31:0] psw_m(int b);
    return (b == 0) ? 32'h0000_08FF : 32'h0000_0FFF;
  endfunction
  function automatic logic [31:0] pc_m(int b);
    return (b == 0) ? 32'h03FF_FFFE : 32'hFFFF_FFFE;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // driver: events with optional simultaneous software write
  task automatic evt_wr(logic [3:0] req, logic [31:0] psw, logic [31:0] pc,
                        bit we, logic [2:0] sel, logic [31:0] wd);
    int b, wb;
    b = pick(req);
    wb = int'(sel[2:1]);
    if (b >= 0) begin
      m_psw[b] = psw & psw_m(b);
      m_pc[b]  = pc & pc_m(b);
    end
    if (we && wb != b) begin
      if (sel[0]) m_pc[wb]  = wd & pc_m(wb);
      else        m_psw[wb] = wd & psw_m(wb);
    end
    evt_req = req; cur_psw = psw; cur_pc = pc;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    tick();
    evt_req = '0; reg_we = 0;
  endtask

  task automatic rd(logic [2:0] sel, string tag);
    int b;
    logic [31:0] e;
    b = int'(sel[2:1]);
    e = sel[0] ? m_pc[b] : m_psw[b];
    if (b == 2 && !m_win) e = '0;
    reg_sel = sel;
    #1;
    chk(reg_rdata === e, tag, reg_rdata, e);
  endtask

  task automatic do_ret(logic [3:0] req);
    int b;
    b = pick(req);
    if (b >= 0) begin
      exp_q.push_back('{b: 2'(b), psw: m_psw[b], pc: m_pc[b]});
      if (b == 2) m_win = 0;
    end
    ret_req = req;
    tick();
    ret_req = '0;
  endtask

  task automatic vec(logic [31:0] a);
    vec_valid = 1; vec_addr = a;
    if (a == 32'h60) m_win = 1;
    tick();
    vec_valid = 0;
  endtask

  // monitor: scoreboard of restore beats (R8)
  always @(negedge clk) begin
    if (rst_n && ret_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected restore beat", 32'(ret_bank), 32'hFFFF_FFFF);
      end else begin
        ret_t e;
        e = exp_q.pop_front();
        chk(ret_bank == e.b, "R8 ret_bank", 32'(ret_bank), 32'(e.b));
        chk(ret_psw == e.psw, "R8 ret_psw", ret_psw, e.psw);
        chk(ret_pc == e.pc, "R8 ret_pc", ret_pc, e.pc);
      end
    end
  end

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_psw[i] = '0; m_pc[i] = '0; end
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    for (int s = 0; s < 8; s++) rd(3'(s), "R1 reset read");
    chk(ret_valid === 1'b0, "R1 ret_valid after reset", 32'(ret_valid), 0);
    vec(32'h60);
    rd(3'd4, "R1 window opens on empty debug bank");
    do_ret(4'b0100);
    // R2 maskable bank masks
    evt_wr(4'b0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
    rd(3'd0, "R2 int psw mask"); rd(3'd1, "R2 int pc mask");
    chk(m_psw[0] == 32'h8FF && m_pc[0] == 32'h03FF_FFFE, "R2 model", m_pc[0], 32'h03FF_FFFE);
    // R3 nmi and call banks
    evt_wr(4'b0010, 32'hA5A5_F123, 32'h8000_1235, 0, 0, 0);
    rd(3'd2, "R3 nmi psw"); rd(3'd3, "R3 nmi pc");
    evt_wr(4'b1000, 32'h1234_5ABC, 32'hDEAD_BEEF, 0, 0, 0);
    rd(3'd6, "R3 call psw"); rd(3'd7, "R3 call pc");
    // R4 debug bank gated read
    evt_wr(4'b0100, 32'h0000_0777, 32'h0000_4001, 0, 0, 0);
    rd(3'd4, "R4 closed window psw"); rd(3'd5, "R4 closed window pc");
    vec(32'h64);
    rd(3'd4, "R4 decoy vector keeps window closed");
    vec(32'h60);
    rd(3'd4, "R4 open window psw"); rd(3'd5, "R4 open window pc");
    // R9 debug return closes window
    do_ret(4'b0100);
    rd(3'd4, "R9 closed after debug return");
    chk(ret_valid === 1'b1, "R8 pulse high", 32'(ret_valid), 1);
    tick();
    chk(ret_valid === 1'b0, "R8 pulse one cycle", 32'(ret_valid), 0);
    // R8 restore of debug bank is not gated
    do_ret(4'b0100);
    // R5 priority
    evt_wr(4'b1111, 32'h0000_0ABC, 32'h0000_2222, 0, 0, 0);
    for (int s = 0; s < 8; s++) rd(3'(s), "R5 only nmi bank written");
    evt_wr(4'b1101, 32'h0000_0333, 32'h0000_3334, 0, 0, 0);
    vec(32'h60);
    for (int s = 0; s < 8; s++) rd(3'(s), "R5 debug beats int and call");
    // R6 software writes with masks
    evt_wr(4'b0000, 0, 0, 1, 3'd1, 32'hFFFF_FFFF);
    rd(3'd1, "R6 int pc write mask");
    evt_wr(4'b0000, 0, 0, 1, 3'd0, 32'hFFFF_FFFF);
    rd(3'd0, "R6 int psw write mask");
    evt_wr(4'b0000, 0, 0, 1, 3'd7, 32'h1357_9BDF);
    rd(3'd7, "R6 call pc bit0 dropped");
    // R7 capture beats write to same bank; other bank still written
    evt_wr(4'b0010, 32'h0000_0111, 32'h0000_0100, 1, 3'd3, 32'h5555_5555);
    rd(3'd3, "R7 capture wins same bank");
    evt_wr(4'b0011, 32'h0000_0222, 32'h0000_0200, 1, 3'd1, 32'h0000_0AAA);
    rd(3'd1, "R7 losing bank write applied");
    rd(3'd3, "R7 winner captured");
    // R10 nested overwrite
    evt_wr(4'b0001, 32'h0000_0801, 32'h0000_1000, 0, 0, 0);
    evt_wr(4'b0001, 32'h0000_0002, 32'h0000_2000, 0, 0, 0);
    rd(3'd0, "R10 second event overwrites psw"); rd(3'd1, "R10 second event overwrites pc");
    // R8 restore priority and each bank
    do_ret(4'b1111);
    do_ret(4'b1001);
    do_ret(4'b1000);
    tick();
    chk(exp_q.size() == 0, "R8 all restores seen", 32'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule